// File: doc/BRIEF.md
# Stack Pair Transfer Unit

This block moves a 16-bit register pair between a register file and a byte-wide memory, using a 16-bit stack pointer that the block owns. The surrounding core decodes the instruction and then hands over three things: an operation code, the pair's upper byte and the pair's lower byte. The block then sequences the memory traffic one byte at a time and returns the resulting pair. When the accumulator and status register are handled as a pair, the accumulator is the upper byte and the flag register is the lower byte. The block treats them like any other pair.

Four operations are supported:
- **Push** stores the pair below the current top of stack.
- **Pop** takes the pair back off the stack.
- **Exchange** swaps the pair with the two bytes at the top of the stack and leaves the pointer where it was.
- **Load pointer** copies the pair into the stack pointer.

The memory side is a plain request/ready handshake that carries one byte per accepted cycle. Operation codes are 00 for push, 01 for pop, 10 for exchange and 11 for load pointer.

Top module: `stk_xfer_unit`

## Requirements
- R1: Push with pointer S writes the upper byte at S-1 and then the lower byte at S-2, in that order. The pointer ends at S-2.
- R2: Pop with pointer S reads the lower byte from S and then the upper byte from S+1, in that order. The pointer ends at S+2. The pair returned on `pair_hi_o`/`pair_lo_o` holds those bytes, and `pair_wr_o` is 1 during `done_o`.
- R3: A push followed by a pop at the same pointer returns the identical pair. This holds for an accumulator/flags pair as for any other.
- R4: Exchange reads S and then S+1. It then writes the old lower register byte to S and the old upper register byte to S+1. The returned pair is the memory contents from before the writes (upper from S+1, lower from S), and `pair_wr_o` is 1.
- R5: Exchange leaves the stack pointer unchanged for its whole duration.
- R6: Load pointer sets the pointer to {upper, lower} and makes no memory access. The returned pair equals the input pair, and `pair_wr_o` is 0.
- R7: Every pointer step, and every address derived from the pointer, wraps modulo 2^16. For example, a push at 0x0000 writes 0xFFFF and then 0xFFFE.
- R8: While `mem_req_o` is high and `mem_rdy_i` is low, address, write data and write enable hold their values, and the operation does not advance.
- R9: `done_o` is high for exactly one cycle. That cycle immediately follows the edge that accepts the final access, or follows the start edge for load pointer. `start_i` has no effect while `busy_o` is high.
- R10: After reset the pointer equals `SP_RESET` (default 0x0000), and `busy_o`, `done_o` and `mem_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| op_i | input | 2 | Operation code (00 push, 01 pop, 10 exchange, 11 load pointer) |
| pair_hi_i | input | 8 | Upper register byte of the pair |
| pair_lo_i | input | 8 | Lower register byte of the pair |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| pair_wr_o | output | 1 | With done: the returned pair must be written back |
| pair_hi_o | output | 8 | Returned upper byte, valid with done |
| pair_lo_o | output | 8 | Returned lower byte, valid with done |
| sp_o | output | 16 | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access accepted at this edge |

## Verification
Two situations are hard to reach from the ports. The first is a start request that arrives in the middle of a stalled operation. The second is an exchange whose two bytes straddle the 0xFFFF/0x0000 boundary. The bench's memory responder inserts a configurable number of wait cycles before each ready, which keeps a push busy long enough to pulse a load-pointer start partway through it. The test then confirms that the pointer and the access stream show no trace of that request. The wrap case is reached by loading the pointer with 0xFFFF through the load operation and then exchanging, so that the scoreboard expects accesses at 0xFFFF and 0x0000.

// File: rtl/stk_pkg.sv
// Package: shared types for the stack pair transfer unit.
// Assumes: byte-wide memory and a pointer of two bytes.
package stk_pkg;

    localparam int unsigned MAX_STEPS = 4;
    localparam int unsigned STEP_W    = $clog2(MAX_STEPS);

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_XCHG = 2'b10,
        OP_LDSP = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_DONE   = 2'd2
    } stk_phase_e;

    typedef enum logic [1:0] {
        AO_SP    = 2'd0,
        AO_PLUS  = 2'd1,
        AO_MINUS = 2'd2
    } addr_off_e;

    typedef enum logic [1:0] {
        SA_HOLD = 2'd0,
        SA_INC  = 2'd1,
        SA_DEC  = 2'd2
    } sp_act_e;

    typedef struct packed {
        logic      we;
        addr_off_e off;
        logic      hi_byte;
        sp_act_e   act;
        logic      last;
    } step_t;

    // Per-operation access plan: what each step addresses, moves and does to the pointer.
    function automatic step_t step_plan(stk_op_e op, logic [STEP_W-1:0] idx);
        step_t s;
        s = '{we: 1'b0, off: AO_SP, hi_byte: 1'b0, act: SA_HOLD, last: 1'b1};
        case (op)
            OP_PUSH: begin
                s.we   = 1'b1;
                s.off  = AO_MINUS;
                s.act  = SA_DEC;
                s.hi_byte = (idx == STEP_W'(0));
                s.last    = (idx == STEP_W'(1));
            end
            OP_POP: begin
                s.off  = AO_SP;
                s.act  = SA_INC;
                s.hi_byte = (idx == STEP_W'(1));
                s.last    = (idx == STEP_W'(1));
            end
            OP_XCHG: begin
                s.we      = idx[1];
                s.off     = idx[0] ? AO_PLUS : AO_SP;
                s.hi_byte = idx[0];
                s.act     = SA_HOLD;
                s.last    = (idx == STEP_W'(3));
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/stk_sp_reg.sv
// Module: stack pointer register with load, increment and decrement.
// Assumes: at most one of inc/dec per cycle; load has priority; wraps modulo 2^W.
module stk_sp_reg #(
    parameter int unsigned W         = 16,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] sp
);

    // Pointer update: reset, load, or one step up/down.
    always_ff @(posedge clk) begin
        if (!rst_n)      sp <= RESET_VAL;
        else if (load)   sp <= load_val;
        else if (inc)    sp <= sp + W'(1);
        else if (dec)    sp <= sp - W'(1);
    end

    // R7: stepping up from all-ones lands on zero.
    p_sp_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && sp == '1) |=> (sp == '0));

    // R7: stepping down from zero lands on all-ones.
    p_sp_wrap_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !inc && sp == '0) |=> (sp == '1));

endmodule

// File: rtl/stk_seq.sv
// Module: operation sequencer. Latches the operation on start, walks the
// step plan one accepted access at a time, and pulses done once.
// Assumes: start is honoured only in the idle phase.
module stk_seq
    import stk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  stk_op_e             op_in,
    input  logic                mem_rdy,
    output stk_op_e             cur_op,
    output stk_phase_e          phase,
    output step_t               plan,
    output logic                mem_req,
    output logic                accept,
    output logic                launch,
    output logic                busy,
    output logic                done
);

    logic [STEP_W-1:0] step_idx;

    // Decode the current step and the handshake state.
    always_comb begin
        plan    = step_plan(cur_op, step_idx);
        mem_req = (phase == PH_ACCESS);
        accept  = mem_req && mem_rdy;
        launch  = (phase == PH_IDLE) && start;
        busy    = (phase != PH_IDLE);
        done    = (phase == PH_DONE);
    end

    // Phase and step progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cur_op   <= OP_PUSH;
            step_idx <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    cur_op   <= op_in;
                    step_idx <= '0;
                    phase    <= (op_in == OP_LDSP) ? PH_DONE : PH_ACCESS;
                end
                PH_ACCESS: if (accept) begin
                    if (plan.last) phase <= PH_DONE;
                    else           step_idx <= step_idx + STEP_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: the completion pulse lasts exactly one cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a start seen mid-operation does not replace the latched operation.
    p_op_held_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACCESS) |=> $stable(cur_op));

    // R8: without ready, the step does not advance.
    p_no_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (phase == PH_ACCESS) && $stable(step_idx));

endmodule

// File: rtl/stk_pair_path.sv
// Module: pair data path. Holds the register bytes given at start (the
// source for writes) and the result bytes (filled from reads).
// Assumes: launch and capture never coincide.
module stk_pair_path #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [DW-1:0] hi_in,
    input  logic [DW-1:0] lo_in,
    input  logic          capture,
    input  logic          cap_hi,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] reg_hi,
    output logic [DW-1:0] reg_lo,
    output logic [DW-1:0] res_hi,
    output logic [DW-1:0] res_lo
);

    // Register copies: loaded once per operation, untouched by reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_hi <= '0;
            reg_lo <= '0;
        end else if (launch) begin
            reg_hi <= hi_in;
            reg_lo <= lo_in;
        end
    end

    // Result bytes: default to the input pair, overwritten by read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
        end else if (launch) begin
            res_hi <= hi_in;
            res_lo <= lo_in;
        end else if (capture) begin
            if (cap_hi) res_hi <= rdata;
            else        res_lo <= rdata;
        end
    end

    // R4: read captures never disturb the register copies used for writes.
    p_regs_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !launch) |=> $stable(reg_hi) && $stable(reg_lo));

endmodule

// File: rtl/stk_xfer_unit.sv
// Module: stack pair transfer unit (top). Sequences push, pop, exchange
// with top of stack, and load of the stack pointer, one memory byte per
// accepted request.
// Assumes: the caller holds start until it sees busy, and writes back the
// returned pair when done and pair_wr are both high.
module stk_xfer_unit
    import stk_pkg::*;
#(
    parameter int unsigned          DW       = 8,
    parameter logic [2*DW-1:0]      SP_RESET = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [DW-1:0]   pair_hi_i,
    input  logic [DW-1:0]   pair_lo_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            pair_wr_o,
    output logic [DW-1:0]   pair_hi_o,
    output logic [DW-1:0]   pair_lo_o,
    output logic [2*DW-1:0] sp_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [2*DW-1:0] mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    input  logic            mem_rdy_i
);

    localparam int unsigned AW = 2 * DW;

    stk_op_e    cur_op;
    stk_phase_e phase;
    step_t      plan;
    logic       accept, launch;
    logic       sp_load, sp_inc, sp_dec;
    logic [DW-1:0] reg_hi, reg_lo;

    stk_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .op_in   (stk_op_e'(op_i)),
        .mem_rdy (mem_rdy_i),
        .cur_op  (cur_op),
        .phase   (phase),
        .plan    (plan),
        .mem_req (mem_req_o),
        .accept  (accept),
        .launch  (launch),
        .busy    (busy_o),
        .done    (done_o)
    );

    // Pointer controls from the launch decode and the accepted step.
    always_comb begin
        sp_load = launch && (stk_op_e'(op_i) == OP_LDSP);
        sp_inc  = accept && (plan.act == SA_INC);
        sp_dec  = accept && (plan.act == SA_DEC);
    end

    stk_sp_reg #(.W(AW), .RESET_VAL(SP_RESET)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sp_load),
        .load_val ({pair_hi_i, pair_lo_i}),
        .inc      (sp_inc),
        .dec      (sp_dec),
        .sp       (sp_o)
    );

    stk_pair_path #(.DW(DW)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .hi_in   (pair_hi_i),
        .lo_in   (pair_lo_i),
        .capture (accept && !plan.we),
        .cap_hi  (plan.hi_byte),
        .rdata   (mem_rdata_i),
        .reg_hi  (reg_hi),
        .reg_lo  (reg_lo),
        .res_hi  (pair_hi_o),
        .res_lo  (pair_lo_o)
    );

    // Memory request fields derived from pointer and step plan.
    always_comb begin
        case (plan.off)
            AO_PLUS:  mem_addr_o = sp_o + AW'(1);
            AO_MINUS: mem_addr_o = sp_o - AW'(1);
            default:  mem_addr_o = sp_o;
        endcase
        mem_we_o    = mem_req_o && plan.we;
        mem_wdata_o = plan.hi_byte ? reg_hi : reg_lo;
    end

    // Write-back flag for operations that change the pair.
    always_comb begin
        pair_wr_o = done_o && ((cur_op == OP_POP) || (cur_op == OP_XCHG));
    end

    // R8: an unanswered request keeps every field steady.
    p_hold_until_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o));

    // R5: the pointer stays put throughout an exchange.
    p_xchg_sp_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACCESS && cur_op == OP_XCHG) |=> $stable(sp_o));

    // R6: loading the pointer makes no memory request.
    p_ldsp_no_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cur_op == OP_LDSP) |-> !mem_req_o);

    // R9: the completion cycle carries no request.
    p_no_req_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

endmodule

// File: tb/stk_xfer_unit_tb.sv
// Bench: scoreboard of expected memory accesses, fed by the operation
// driver and drained by the memory responder as accesses are accepted.
module stk_xfer_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [7:0]  pair_hi_i = '0, pair_lo_i = '0;
    logic        busy_o, done_o, pair_wr_o;
    logic [7:0]  pair_hi_o, pair_lo_o;
    logic [15:0] sp_o;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        mem_rdy_i = 1'b0;

    int checks = 0;
    int errors = 0;
    int stall_len = 0;
    int wait_cnt = 0;
    logic [7:0]  mem [256];
    logic [15:0] model_sp;

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
        string       req;
    } acc_t;
    acc_t exp_q[$];

    always #4 clk = ~clk;

    stk_xfer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .pair_hi_i(pair_hi_i), .pair_lo_i(pair_lo_i),
        .busy_o(busy_o), .done_o(done_o), .pair_wr_o(pair_wr_o),
        .pair_hi_o(pair_hi_o), .pair_lo_o(pair_lo_o), .sp_o(sp_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory responder and monitor: stalls, answers, compares against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            mem_rdy_i = 1'b0;
            if (mem_req_o) begin
                if (wait_cnt >= stall_len) begin
                    wait_cnt  = 0;
                    mem_rdy_i = 1'b1;
                    if (exp_q.size() == 0) begin
                        chk("R8", "unexpected access addr", {16'h0, mem_addr_o}, 32'hFFFF_FFFF);
                    end else begin
                        acc_t e;
                        e = exp_q.pop_front();
                        chk(e.req, "access we", {31'h0, mem_we_o}, {31'h0, e.we});
                        chk(e.req, "access addr", {16'h0, mem_addr_o}, {16'h0, e.addr});
                        if (e.we) chk(e.req, "access wdata", {24'h0, mem_wdata_o}, {24'h0, e.data});
                    end
                    if (mem_we_o) mem[mem_addr_o[7:0]] = mem_wdata_o;
                    else          mem_rdata_i = mem[mem_addr_o[7:0]];
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    function automatic acc_t mk(input logic we, input logic [15:0] a, input logic [7:0] d, input string r);
        acc_t x;
        x.we = we; x.addr = a; x.data = d; x.req = r;
        return x;
    endfunction

    // Driver: computes the expected accesses and results, runs one operation.
    task automatic run_op(input logic [1:0] o, input logic [7:0] h, input logic [7:0] l,
                          input int stall, input bit poke, input string req);
        logic [7:0]  eh, el;
        logic [15:0] esp;
        logic        ewr;
        int          cnt;
        stall_len = stall;
        wait_cnt  = 0;
        case (o)
            2'b00: begin
                exp_q.push_back(mk(1'b1, model_sp - 16'd1, h, req));
                exp_q.push_back(mk(1'b1, model_sp - 16'd2, l, req));
                esp = model_sp - 16'd2; eh = h; el = l; ewr = 1'b0;
            end
            2'b01: begin
                exp_q.push_back(mk(1'b0, model_sp, 8'h0, req));
                exp_q.push_back(mk(1'b0, model_sp + 16'd1, 8'h0, req));
                el = mem[model_sp[7:0]]; eh = mem[8'(model_sp[7:0] + 8'd1)];
                esp = model_sp + 16'd2; ewr = 1'b1;
            end
            2'b10: begin
                exp_q.push_back(mk(1'b0, model_sp, 8'h0, req));
                exp_q.push_back(mk(1'b0, model_sp + 16'd1, 8'h0, req));
                exp_q.push_back(mk(1'b1, model_sp, l, req));
                exp_q.push_back(mk(1'b1, model_sp + 16'd1, h, req));
                el = mem[model_sp[7:0]]; eh = mem[8'(model_sp[7:0] + 8'd1)];
                esp = model_sp; ewr = 1'b1;
            end
            default: begin
                esp = {h, l}; eh = h; el = l; ewr = 1'b0;
            end
        endcase
        @(negedge clk);
        start_i = 1'b1; op_i = o; pair_hi_i = h; pair_lo_i = l;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0;
        while (!done_o && cnt < 300) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 2) begin
                start_i = 1'b1; op_i = 2'b11; pair_hi_i = 8'h00; pair_lo_i = 8'h00;
            end
            if (poke && cnt == 3) start_i = 1'b0;
        end
        chk(req, "done seen", {31'h0, done_o}, 32'h1);
        chk(req, "pair hi", {24'h0, pair_hi_o}, {24'h0, eh});
        chk(req, "pair lo", {24'h0, pair_lo_o}, {24'h0, el});
        chk(req, "pair_wr", {31'h0, pair_wr_o}, {31'h0, ewr});
        chk(req, "sp", {16'h0, sp_o}, {16'h0, esp});
        chk(req, "accesses left", exp_q.size(), 0);
        exp_q.delete();
        model_sp = esp;
        @(negedge clk);
        chk("R9", "done one cycle", {31'h0, done_o}, 32'h0);
        if (poke) begin
            @(negedge clk);
            chk("R9", "no request after ignored start", {31'h0, mem_req_o}, 32'h0);
            chk("R9", "sp after ignored start", {16'h0, sp_o}, {16'h0, esp});
            chk("R9", "no done after ignored start", {31'h0, done_o}, 32'h0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Main sequence.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "reset sp", {16'h0, sp_o}, 32'h0);
        chk("R10", "reset busy", {31'h0, busy_o}, 32'h0);
        chk("R10", "reset done", {31'h0, done_o}, 32'h0);
        chk("R10", "reset req", {31'h0, mem_req_o}, 32'h0);
        model_sp = 16'h0000;

        run_op(2'b00, 8'hA5, 8'h3C, 0, 1'b0, "R1");   // push at 0000 wraps (R7)
        run_op(2'b01, 8'h00, 8'h00, 0, 1'b0, "R2");   // pop back over wrap (R7)
        run_op(2'b11, 8'h12, 8'h40, 0, 1'b0, "R6");
        run_op(2'b00, 8'h8E, 8'hD7, 2, 1'b0, "R8");   // accumulator/flags push, stalled
        run_op(2'b10, 8'h11, 8'h22, 1, 1'b0, "R4");   // exchange, R5 pointer fixed
        run_op(2'b01, 8'h00, 8'h00, 0, 1'b0, "R3");   // returns exchanged pair
        run_op(2'b00, 8'hC3, 8'h96, 0, 1'b0, "R3");
        run_op(2'b01, 8'h00, 8'h00, 3, 1'b0, "R3");   // round trip
        run_op(2'b00, 8'h77, 8'h66, 3, 1'b1, "R9");   // start ignored while busy
        run_op(2'b11, 8'hFF, 8'hFF, 0, 1'b0, "R6");
        run_op(2'b10, 8'hB1, 8'hB2, 0, 1'b0, "R7");   // exchange straddles FFFF/0000
        chk("R5", "sp after wrap exchange", {16'h0, sp_o}, 32'hFFFF);
        chk("R7", "mem at 0000", {24'h0, mem[8'h00]}, 32'hB1);
        chk("R7", "mem at FFFF", {24'h0, mem[8'hFF]}, 32'hB2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule